// File: doc/BRIEF.md
# Four-Phase Register-File Sequencer

This block is a minimal processing core. Each instruction takes four clocks, and the single-port register RAM is accessed exactly once per clock. The RAM holds both the program and the data. Operands are gathered in the first three phases, and the result is written back in the fourth.

Three addresses map to live registers instead of RAM:

- **Free-running counter.** Its address reads the live counter as a source. As a destination, the same address is an ordinary RAM shadow word.
- **Phase accumulator.** It adds a frequency value on every clock.
- **Frequency register.** It holds the value the accumulator adds.

Live sources are selected only in the third phase, so the value copied depends on the exact clock of that phase. A jump through the accumulator lands at one address and then continues from another. This is intended behaviour.

The core is loaded through a preload port while reset is held. After reset is released it runs the program on its own. The program counter, the phase and every write-back appear on observation outputs.

Top module: `quad_phase_core`

## Requirements
- R1: Phases run 0,1,2,3 in order and repeat. While reset is held, the phase is 2 and the program counter is all ones. The first instruction is therefore fetched from address 0 and begins its phase 0 two clocks after reset is released.
- R2: Instruction word layout:
  - bits [31:19] opcode: 0 no-op, 1 move, 2 add, 3 jump, 4 wait;
  - bit [18] immediate flag;
  - bits [17:9] destination address;
  - bits [8:0] source address or immediate value.
  An immediate is zero-extended, so 0x1FF yields 511.
- R3: A write-back is issued only in phase 3, and only for move, add, and a released wait. Move writes the source value. Add writes the destination operand plus the source value. The port shows the write enable, the address and the data.
- R4: The counter is 0 in the clock after reset and increments every clock. A non-immediate source at the counter address (0x1F0) reads the live counter in phase 2. That value equals the counter at the instruction's phase 0 plus 2.
- R5: As a destination, the counter address is an ordinary RAM word. The destination operand of every instruction is always read from RAM, so an add to 0x1F0 adds to the stored shadow word and not to the live counter.
- R6: Frequency register (address 0x1F4) and accumulator (address 0x1F8):
  - A write to 0x1F4 loads the frequency register.
  - The accumulator adds the frequency value on every clock.
  - A write to 0x1F8 replaces the accumulator at the end of phase 3.
  - As non-immediate sources, 0x1F4 and 0x1F8 read the live registers in phase 2.
- R7: A jump works in two steps:
  - Phase 2 fetches the next instruction from the source value seen in phase 2.
  - At the end of phase 3 the program counter is loaded with the source value seen in phase 3.
  - The following fetch uses that counter plus 1.
  For an accumulator holding base B with frequency F at the jump's phase 0, execution lands at B+2F and then continues at B+3F+1.
- R8: A non-jump instruction fetches from the program counter plus 1 and advances the counter by one. During an instruction the counter output holds the value that the instruction's own fetch was based on.
- R9: Wait stays in phase 3 until the counter equals the destination operand. It then writes the destination operand plus the source value. If they are equal on the first phase-3 clock, there is no stall.
- R10: While reset is held, a preload strobe writes the given word into RAM at the given address.
- R11: No-op and unused opcodes write nothing and advance the program counter by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; enables preload |
| ld_en | input | 1 | Preload write strobe (used only in reset) |
| ld_addr | input | 9 | Preload RAM address |
| ld_data | input | 32 | Preload RAM word |
| pc_o | output | 9 | Program counter |
| phase_o | output | 2 | Current phase |
| wb_en | output | 1 | Write-back enable this clock |
| wb_addr | output | 9 | Write-back address |
| wb_data | output | 32 | Write-back data |

## Verification
The bench builds the core with its defaults: a 9-bit address (512 words), 32-bit data, and the live registers at 0x1F0, 0x1F4 and 0x1F8. It runs one preloaded program and checks the write-back port and the phase on every clock over the first hundred clocks after reset. Every expected value is derived arithmetically from the start clock of each instruction.

With the narrow default address, the program reaches several cases in a short run:
- the copied counter value;
- the shadow-word alias;
- the accumulator jump landing at B+2F and continuing at B+3F+1;
- a wait that stalls;
- a wait that releases at once.

// File: rtl/quad_phase_core.sv
module quad_phase_core #(
  parameter int AW = 9,
  parameter int DW = 32,
  parameter logic [AW-1:0] CNT_A = 'h1F0,
  parameter logic [AW-1:0] FRQ_A = 'h1F4,
  parameter logic [AW-1:0] PHS_A = 'h1F8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic [AW-1:0] pc_o,
  output logic [1:0]    phase_o,
  output logic          wb_en,
  output logic [AW-1:0] wb_addr,
  output logic [DW-1:0] wb_data
);
  localparam int OPW   = DW - 2*AW - 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [OPW-1:0] OP_MOV  = OPW'(1);
  localparam logic [OPW-1:0] OP_ADD  = OPW'(2);
  localparam logic [OPW-1:0] OP_JMP  = OPW'(3);
  localparam logic [OPW-1:0] OP_WAIT = OPW'(4);

  logic [DW-1:0] ram [DEPTH];
  logic [1:0]    ph;
  logic [AW-1:0] pc, addr, fetch_a;
  logic [DW-1:0] ir, rd, s_lat, d_lat, s_fin, cnt, phs, frq, live_src, result;
  logic [OPW-1:0] op;
  logic          imm, hit, we, advance;
  logic [AW-1:0] dst, src;

  assign op  = ir[DW-1:2*AW+1];
  assign imm = ir[2*AW];
  assign dst = ir[2*AW-1:AW];
  assign src = ir[AW-1:0];

  always_comb begin
    live_src = s_lat;
    if (!imm) begin
      if (src == CNT_A)      live_src = cnt;
      else if (src == PHS_A) live_src = phs;
      else if (src == FRQ_A) live_src = frq;
    end
  end

  assign hit     = (cnt == d_lat);
  assign we      = !rst && ph == 2'd3 &&
                   (op == OP_MOV || op == OP_ADD || (op == OP_WAIT && hit));
  assign result  = (op == OP_MOV) ? s_fin : d_lat + s_fin;
  assign advance = !(ph == 2'd3 && op == OP_WAIT && !hit);
  assign fetch_a = (op == OP_JMP) ? live_src[AW-1:0] : pc + 1'b1;

  always_comb begin
    case (ph)
      2'd0:    addr = src;
      2'd2:    addr = fetch_a;
      default: addr = dst;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if (ld_en) ram[ld_addr] <= ld_data;
    end else if (we) begin
      ram[dst] <= result;
    end else if (ph != 2'd3) begin
      rd <= ram[addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= 2'd2; pc <= '1; ir <= '0;
      cnt <= '0; phs <= '0; frq <= '0;
      s_lat <= '0; d_lat <= '0; s_fin <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      phs <= (we && dst == PHS_A) ? result : phs + frq;
      if (we && dst == FRQ_A) frq <= result;
      case (ph)
        2'd1: s_lat <= imm ? {{(DW-AW){1'b0}}, src} : rd;
        2'd2: begin d_lat <= rd; s_fin <= live_src; end
        2'd3: if (advance) begin
                ir <= rd;
                pc <= (op == OP_JMP) ? live_src[AW-1:0] : pc + 1'b1;
              end
        default: ;
      endcase
      if (advance) ph <= ph + 2'd1;
    end
  end

  assign pc_o    = pc;
  assign phase_o = ph;
  assign wb_en   = we;
  assign wb_addr = dst;
  assign wb_data = result;

  assert_phase_step_R1: assert property (@(posedge clk) disable iff (rst)
    (ph != 2'd3) |=> (ph == $past(ph) + 2'd1));

  assert_cnt_step_R4: assert property (@(posedge clk) disable iff (rst)
    (ph != 2'd3) |=> (cnt == $past(cnt) + 1'b1));

  assert_cnt_copy_R4: assert property (@(posedge clk) disable iff (rst)
    (ph == 2'd3 && op == OP_MOV && !imm && src == CNT_A) |-> (s_fin == cnt - 1'b1));

  assert_wait_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (ph == 2'd3 && op == OP_WAIT && !hit) |=> (ph == 2'd3 && $stable(pc) && $stable(ir)));

  assert_ir_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (ph != 2'd3) |=> ($stable(ir) && $stable(pc)));

  assert_jump_live_R7: assert property (@(posedge clk) disable iff (rst)
    (ph == 2'd2 && op == OP_JMP && !imm && src == PHS_A)
      |=> ##1 (pc == $past(fetch_a, 2) + $past(frq[AW-1:0], 2)));
endmodule

// File: tb/test_quad_phase_core.sv
module test_quad_phase_core;
  localparam int AW = 9, DW = 32;
  localparam int CNT = 'h1F0, FRQ = 'h1F4, PHS = 'h1F8;

  logic clk = 0, rst = 1, ld_en = 0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic [AW-1:0] pc_o, wb_addr;
  logic [1:0]    phase_o;
  logic          wb_en;
  logic [DW-1:0] wb_data;

  quad_phase_core i_quad_phase_core (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .pc_o(pc_o), .phase_o(phase_o), .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data));

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] enc(int op, bit im, int d, int s);
    return {13'(op), im, 9'(d), 9'(s)};
  endfunction

  task automatic ld(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    ld_en = 1; ld_addr = AW'(a); ld_data = d;
  endtask

  initial begin
    ld(0,  enc(1, 1, 'h10, 5));
    ld(1,  enc(2, 1, 'h10, 7));
    ld(2,  enc(1, 0, 'h11, CNT));
    ld(3,  enc(1, 1, CNT, 100));
    ld(4,  enc(2, 0, 'h11, CNT));
    ld(5,  enc(2, 1, CNT, 1));
    ld(6,  enc(1, 1, FRQ, 3));
    ld(7,  enc(1, 1, PHS, 40));
    ld(8,  enc(3, 0, 0, PHS));
    ld(46, enc(1, 0, 'h13, PHS));
    for (int a = 47; a < 60; a++) if (a != 50) ld(a, enc(1, 1, 'h20, 'h1AA));
    ld(50, enc(3, 1, 0, 60));
    ld(60, enc(1, 1, 'h14, 'h1FF));
    ld(61, enc(1, 1, 'h15, 60));
    ld(62, enc(4, 1, 'h15, 4));
    ld(63, enc(1, 0, 'h16, CNT));
    ld(64, enc(4, 1, 'h17, 0));
    ld('h17, 32'd68);
    ld(65, enc(7, 1, 'h18, 9));
    ld(66, enc(3, 1, 0, 66));
    @(negedge clk);
    ld_en = 0;
    @(negedge clk); #1;
    chk("R1 reset pc", pc_o, 511);
    chk("R1 reset phase", phase_o, 2);
    chk("R3 reset no write", wb_en, 0);

    @(negedge clk);
    rst = 0;
    for (int cyc = 0; cyc <= 100; cyc++) begin
      bit e_en; int e_addr; int e_data; string tag; int e_ph;
      if (cyc > 0) @(negedge clk);
      #1;
      e_en = 1; e_addr = 0; e_data = 0; tag = "";
      case (cyc)
        5:  begin e_addr = 'h10; e_data = 5;   tag = "R2 R10 move imm"; end
        9:  begin e_addr = 'h10; e_data = 12;  tag = "R3 add"; end
        13: begin e_addr = 'h11; e_data = 12;  tag = "R4 counter copy"; end
        17: begin e_addr = CNT;  e_data = 100; tag = "R5 shadow write"; end
        21: begin e_addr = 'h11; e_data = 32;  tag = "R4 R5 live counter add"; end
        25: begin e_addr = CNT;  e_data = 101; tag = "R5 shadow dest operand"; end
        29: begin e_addr = FRQ;  e_data = 3;   tag = "R6 freq write"; end
        33: begin e_addr = PHS;  e_data = 40;  tag = "R6 accum write"; end
        41: begin e_addr = 'h13; e_data = 58;  tag = "R6 R7 accum copy after jump"; end
        49: begin e_addr = 'h14; e_data = 511; tag = "R2 zero extend"; end
        53: begin e_addr = 'h15; e_data = 60;  tag = "R3 move"; end
        60: begin e_addr = 'h15; e_data = 64;  tag = "R9 wait release"; end
        64: begin e_addr = 'h16; e_data = 63;  tag = "R4 R9 counter after stall"; end
        68: begin e_addr = 'h17; e_data = 68;  tag = "R9 wait no stall"; end
        default: begin e_en = 0; tag = "R3 R11 no write"; end
      endcase
      chk($sformatf("%s en cycle %0d", tag, cyc), wb_en, e_en);
      if (e_en && wb_en) begin
        chk($sformatf("%s addr", tag), wb_addr, e_addr);
        chk($sformatf("%s data", tag), wb_data, e_data);
      end
      e_ph = (cyc < 57) ? (cyc + 2) % 4 : (cyc <= 60) ? 3 : (cyc - 61) % 4;
      chk($sformatf("R1 R9 phase cycle %0d", cyc), phase_o, e_ph);
      case (cyc)
        2:  chk("R1 first instr pc", pc_o, 0);
        6:  chk("R8 pc step", pc_o, 1);
        38: chk("R7 pc after accum jump", pc_o, 49);
        42: chk("R7 R8 fetch base+3F+1", pc_o, 50);
        46: chk("R7 imm jump", pc_o, 60);
        90: chk("R8 R11 pc in loop", pc_o, 66);
        default: ;
      endcase
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule